// File: doc/BRIEF.md
# External Program Fetch Bus Controller

This block connects a small 8-bit microcontroller core to program memory that sits outside the chip. Each request carries a 12-bit program counter. The block splits that address in two. The low byte goes out on a shared 8-bit bus that carries both address and data. The high nibble goes out on the lower four bits of a general-purpose port. An address latch enable strobe marks the moment the external memory should capture the address. An active-low program store enable then lets the memory drive the instruction byte back onto the same bus.

Every machine cycle lasts five clocks. The latch strobe fires once in each cycle, whether or not a fetch is pending, so it can also serve as a cycle clock for other parts of the board.

Not every fetch goes off-chip. The block compares the program counter against a selectable internal ROM size. Addresses below that size are read through an internal ROM read port, and the external strobes stay idle. An external-access strap overrides the comparison and sends every fetch off-chip.

The port nibble keeps its own value in a holding register. The core writes that register through a simple write port. The pins show the held value at all times except while an external fetch is using them for the address.

Top module: `ext_fetch_if`

## Requirements
- R1: `ale` is high for exactly one clock at the start of every five-clock machine cycle, with or without a fetch request.
- R2: `fetch_req`, `pc`, `ea` and `rom_size` are sampled at the clock edge that begins a machine cycle. In phases 1 and 2 of an external fetch, `bus_oe`=1, `bus_out`=pc[7:0] and `p2_lo`=pc[11:8], so the address is stable when `ale` falls.
- R3: `psen_n` is low in phases 3 and 4 of an external fetch and high at every other time. `bus_oe` is 0 whenever `psen_n` is low.
- R4: With `ea`=1, every fetch is external, whatever the value of `pc` or `rom_size`.
- R5: With `ea`=0, a fetch is external exactly when pc >= limit. `rom_size` selects the limit: 0 gives 0, 1 gives 1024, 2 gives 2048, and 3 gives 4096.
- R6: During an internal fetch, `rom_addr` equals the requested pc. `psen_n` stays high and `bus_oe` stays 0 for the whole cycle.
- R7: The instruction byte is taken at the edge that ends phase 4. It comes from `bus_in` for an external fetch and from `rom_data` for an internal one. `instr_valid` pulses for one clock in phase 5 with `instr` holding that byte. A cycle without a request gives no pulse.
- R8: Outside phases 1 to 4 of an external fetch, `p2_lo` shows the held port value. A write with `p2_wr` updates the held value even during a fetch, and the new value appears on the pins in phase 5 of that fetch.
- R9: While `rst_n` is low at a clock edge, the block holds `ale` at 0, `psen_n` at 1, `bus_oe` at 0 and `instr_valid` at 0. It also sets the held port value to 4'hF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fetch_req | input | 1 | Request a fetch in the next machine cycle |
| pc | input | 12 | Program counter to fetch from |
| ea | input | 1 | External-access strap; forces all fetches off-chip |
| rom_size | input | 2 | Internal ROM size code (0, 1K, 2K, 4K) |
| rom_addr | output | 12 | Internal ROM read address |
| rom_data | input | 8 | Internal ROM read data |
| bus_in | input | 8 | Value seen on the shared bus pins |
| bus_out | output | 8 | Value driven onto the shared bus |
| bus_oe | output | 1 | Bus output enable (0 = high impedance) |
| ale | output | 1 | Address latch enable |
| psen_n | output | 1 | Program store enable, active low |
| p2_wr | input | 1 | Write strobe for the held port nibble |
| p2_wdata | input | 4 | Data for the held port nibble |
| p2_lo | output | 4 | Port pins carrying the high address nibble or the held value |
| instr | output | 8 | Fetched instruction byte |
| instr_valid | output | 1 | One-clock pulse when `instr` is new |

## Verification
Two events can land in the same cycle. The core may write the port nibble while an external fetch is using those pins for the address. The bench provokes this by asserting `p2_wr` in phase 2 of an external fetch. It then checks two things: the pins still carry pc[11:8] through phase 4, and the new value appears in phase 5, the same clock as the `instr_valid` pulse. A second sweep covers every strap setting, every ROM size and addresses on each side of every limit. The expected external/internal choice is computed arithmetically, and the byte returned by a modelled external memory is checked against it.

// File: rtl/ext_fetch_pkg.sv
// Package: shared phase encoding for the external fetch controller.
// Assumes a fixed five-clock machine cycle.
package ext_fetch_pkg;
    typedef enum logic [2:0] {
        PH_LATCH = 3'd0,   // phase 1: latch strobe high
        PH_ADDR  = 3'd1,   // phase 2: address held after strobe falls
        PH_RD1   = 3'd2,   // phase 3: store enable low
        PH_RD2   = 3'd3,   // phase 4: store enable low, byte sampled at end
        PH_DONE  = 3'd4    // phase 5: result presented, pins restored
    } efi_phase_e;
endpackage

// File: rtl/efi_sequencer.sv
// efi_sequencer: free-running five-phase machine-cycle counter.
// Produces the latch strobe and the cycle-start qualifier.
// Assumes a synchronous active-low reset; reset parks the counter in the
// last phase, so the strobe is low during reset and fires on the first
// clock after release.
module efi_sequencer
    import ext_fetch_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    output efi_phase_e phase,
    output logic       cyc_start,
    output logic       ale
);
    // Advance the phase each clock and wrap after the last one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_DONE;
        end else begin
            case (phase)
                PH_LATCH: phase <= PH_ADDR;
                PH_ADDR:  phase <= PH_RD1;
                PH_RD1:   phase <= PH_RD2;
                PH_RD2:   phase <= PH_DONE;
                default:  phase <= PH_LATCH;
            endcase
        end
    end

    // Decode the strobe and the edge where the next cycle begins.
    always_comb begin
        ale       = (phase == PH_LATCH);
        cyc_start = (phase == PH_DONE);
    end

    // R1
    ale_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ale |=> !ale);
endmodule

// File: rtl/efi_route.sv
// efi_route: decides whether a fetch address must go off-chip.
// Builds a table of ROM limits from the address width, then compares.
// Assumes the size code selects 0, 1/4, 1/2 or all of the address space.
module efi_route #(
    parameter int PC_W = 12
) (
    input  logic [PC_W-1:0] pc,
    input  logic            ea,
    input  logic [1:0]      rom_size,
    output logic            go_ext
);
    localparam int LIM_W = PC_W + 1;
    localparam logic [LIM_W-1:0] QUARTER = LIM_W'(1) << (PC_W - 2);

    logic [LIM_W-1:0] limit_tab [4];

    // Fill the limit table: size 0 means no internal ROM at all.
    for (genvar g = 0; g < 4; g++) begin : g_lim
        if (g == 0) begin : g_zero
            assign limit_tab[g] = '0;
        end else begin : g_size
            assign limit_tab[g] = QUARTER << (g - 1);
        end
    end

    // Go off-chip when the strap is set or the address lies past the ROM.
    always_comb begin
        go_ext = ea || ({1'b0, pc} >= limit_tab[rom_size]);
    end
endmodule

// File: rtl/efi_fetch_ctl.sv
// efi_fetch_ctl: holds one fetch per machine cycle and returns its byte.
// Captures the request at cycle start and samples the byte at the end of
// phase 4 from the bus or from the internal ROM port.
// Assumes the request inputs are stable at the cycle-start edge.
module efi_fetch_ctl
    import ext_fetch_pkg::*;
#(
    parameter int PC_W   = 12,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  efi_phase_e        phase,
    input  logic              cyc_start,
    input  logic              fetch_req,
    input  logic [PC_W-1:0]   pc,
    input  logic              go_ext,
    input  logic [DATA_W-1:0] bus_in,
    input  logic [DATA_W-1:0] rom_data,
    output logic              cyc_ext,
    output logic [PC_W-1:0]   cyc_addr,
    output logic [DATA_W-1:0] instr,
    output logic              instr_valid
);
    logic cyc_valid;

    // Latch the request and its routing at the start of each cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cyc_valid <= 1'b0;
            cyc_ext   <= 1'b0;
            cyc_addr  <= '0;
        end else if (cyc_start) begin
            cyc_valid <= fetch_req;
            cyc_ext   <= fetch_req && go_ext;
            cyc_addr  <= pc;
        end
    end

    // Sample the byte at the end of phase 4 and pulse the valid flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            instr       <= '0;
            instr_valid <= 1'b0;
        end else if (phase == PH_RD2 && cyc_valid) begin
            instr       <= cyc_ext ? bus_in : rom_data;
            instr_valid <= 1'b1;
        end else begin
            instr_valid <= 1'b0;
        end
    end

    // R7
    valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        instr_valid |=> !instr_valid);
endmodule

// File: rtl/ext_fetch_if.sv
// ext_fetch_if: external program fetch bus controller (top).
// Multiplexes the low address byte onto the shared bus, puts the high
// nibble on the port pins, strobes latch and store enables, and keeps the
// port value in a holding register that returns after each fetch.
// Assumes an external bus driver controlled by bus_oe.
module ext_fetch_if
    import ext_fetch_pkg::*;
#(
    parameter int PC_W   = 12,
    parameter int DATA_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  fetch_req,
    input  logic [PC_W-1:0]       pc,
    input  logic                  ea,
    input  logic [1:0]            rom_size,
    output logic [PC_W-1:0]       rom_addr,
    input  logic [DATA_W-1:0]     rom_data,
    input  logic [DATA_W-1:0]     bus_in,
    output logic [DATA_W-1:0]     bus_out,
    output logic                  bus_oe,
    output logic                  ale,
    output logic                  psen_n,
    input  logic                  p2_wr,
    input  logic [PC_W-DATA_W-1:0] p2_wdata,
    output logic [PC_W-DATA_W-1:0] p2_lo,
    output logic [DATA_W-1:0]     instr,
    output logic                  instr_valid
);
    localparam int HI_W = PC_W - DATA_W;

    efi_phase_e      phase;
    logic            cyc_start;
    logic            go_ext;
    logic            cyc_ext;
    logic [PC_W-1:0] cyc_addr;
    logic [HI_W-1:0] p2_hold;
    logic            addr_ph;
    logic            strobe_ph;

    efi_sequencer u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .phase     (phase),
        .cyc_start (cyc_start),
        .ale       (ale)
    );

    efi_route #(.PC_W(PC_W)) u_route (
        .pc       (pc),
        .ea       (ea),
        .rom_size (rom_size),
        .go_ext   (go_ext)
    );

    efi_fetch_ctl #(.PC_W(PC_W), .DATA_W(DATA_W)) u_ctl (
        .clk         (clk),
        .rst_n       (rst_n),
        .phase       (phase),
        .cyc_start   (cyc_start),
        .fetch_req   (fetch_req),
        .pc          (pc),
        .go_ext      (go_ext),
        .bus_in      (bus_in),
        .rom_data    (rom_data),
        .cyc_ext     (cyc_ext),
        .cyc_addr    (cyc_addr),
        .instr       (instr),
        .instr_valid (instr_valid)
    );

    // Holding register for the port nibble; reset high like an idle port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            p2_hold <= '1;
        end else if (p2_wr) begin
            p2_hold <= p2_wdata;
        end
    end

    // Drive bus, store enable and port pins from the phase and cycle type.
    always_comb begin
        addr_ph   = cyc_ext && (phase == PH_LATCH || phase == PH_ADDR);
        strobe_ph = cyc_ext && (phase == PH_RD1 || phase == PH_RD2);
        bus_oe    = addr_ph;
        bus_out   = cyc_addr[DATA_W-1:0];
        psen_n    = !strobe_ph;
        p2_lo     = (addr_ph || strobe_ph) ? cyc_addr[PC_W-1:DATA_W] : p2_hold;
        rom_addr  = cyc_addr;
    end

    // R3
    psen_busfree_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !psen_n |-> !bus_oe);
    // R3
    psen_ale_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !psen_n |-> !ale);
    // R2
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ale && bus_oe) |=> (bus_oe && $stable(bus_out) && $stable(p2_lo)));
    // R7
    ext_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(psen_n) |-> instr_valid);
endmodule

// File: tb/test_ext_fetch_if.sv
module test_ext_fetch_if;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fetch_req = 1'b0;
    logic [11:0] pc = '0;
    logic        ea = 1'b0;
    logic [1:0]  rom_size = '0;
    logic [11:0] rom_addr;
    logic [7:0]  rom_data;
    logic [7:0]  bus_in;
    logic [7:0]  bus_out;
    logic        bus_oe;
    logic        ale;
    logic        psen_n;
    logic        p2_wr = 1'b0;
    logic [3:0]  p2_wdata = '0;
    logic [3:0]  p2_lo;
    logic [7:0]  instr;
    logic        instr_valid;

    int checks = 0;
    int errors = 0;
    logic [3:0]  hold_exp = 4'hF;
    logic [11:0] lat_addr = '0;

    always #10 clk = ~clk;

    ext_fetch_if i_ext_fetch_if (
        .clk(clk), .rst_n(rst_n), .fetch_req(fetch_req), .pc(pc), .ea(ea),
        .rom_size(rom_size), .rom_addr(rom_addr), .rom_data(rom_data),
        .bus_in(bus_in), .bus_out(bus_out), .bus_oe(bus_oe), .ale(ale),
        .psen_n(psen_n), .p2_wr(p2_wr), .p2_wdata(p2_wdata), .p2_lo(p2_lo),
        .instr(instr), .instr_valid(instr_valid)
    );

    function automatic logic [7:0] ext_mem(input logic [11:0] a);
        return a[7:0] ^ {a[11:8], a[11:8]} ^ 8'h5A;
    endfunction
    function automatic logic [7:0] rom_mem(input logic [11:0] a);
        return (~a[7:0]) + {4'h0, a[11:8]};
    endfunction

    // External memory model: captures the address when the latch strobe falls.
    always @(negedge ale) lat_addr <= {p2_lo, bus_out};
    assign bus_in   = !psen_n ? ext_mem(lat_addr) : 8'hFF;
    assign rom_data = rom_mem(rom_addr);

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    // Entry and exit: at the falling clock inside phase 5.
    task automatic do_cycle(input logic req, input logic [11:0] a, input logic e,
                            input logic [1:0] sz, input logic wr_mid, input logic [3:0] wval);
        int lim;
        logic ext;
        lim = (sz == 0) ? 0 : (1024 << (sz - 1));
        ext = req && (e || (int'(a) >= lim));
        fetch_req = req; pc = a; ea = e; rom_size = sz;
        @(negedge clk); // phase 1
        fetch_req = 1'b0;
        chk(ale == 1'b1, "R1", ale, 1);
        chk(psen_n == 1'b1, "R3", psen_n, 1);
        chk(bus_oe == ext, "R2", bus_oe, ext);
        if (ext) begin
            chk(bus_out == a[7:0], "R2", bus_out, a[7:0]);
            chk(p2_lo == a[11:8], "R2", p2_lo, a[11:8]);
        end else begin
            chk(p2_lo == hold_exp, "R8", p2_lo, hold_exp);
        end
        if (req && !ext) chk(rom_addr == a, "R6", rom_addr, a);
        @(negedge clk); // phase 2
        chk(ale == 1'b0, "R1", ale, 0);
        chk(bus_oe == ext, "R2", bus_oe, ext);
        if (wr_mid) begin
            p2_wr = 1'b1; p2_wdata = wval;
        end
        @(negedge clk); // phase 3
        if (wr_mid) begin
            p2_wr = 1'b0; hold_exp = wval;
        end
        chk(psen_n == !ext, "R3", psen_n, !ext);
        chk(bus_oe == 1'b0, "R6", bus_oe, 0);
        chk(p2_lo == (ext ? a[11:8] : hold_exp), "R8", p2_lo, ext ? a[11:8] : hold_exp);
        @(negedge clk); // phase 4
        chk(psen_n == !ext, "R3", psen_n, !ext);
        chk(ale == 1'b0, "R1", ale, 0);
        @(negedge clk); // phase 5
        chk(psen_n == 1'b1, "R3", psen_n, 1);
        chk(instr_valid == req, "R7", instr_valid, req);
        if (req) begin
            chk(instr == (ext ? ext_mem(a) : rom_mem(a)), ext ? "R4" : "R5",
                instr, ext ? ext_mem(a) : rom_mem(a));
        end
        chk(p2_lo == hold_exp, "R8", p2_lo, hold_exp);
    endtask

    initial begin
        #2000000;
        errors++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [11:0] pcs [10];
        pcs = '{12'h000, 12'h001, 12'h3FF, 12'h400, 12'h401,
                12'h7FF, 12'h800, 12'hA5C, 12'hC3B, 12'hFFF};
        repeat (3) @(negedge clk);
        // R9: reset state
        chk(ale == 1'b0, "R9", ale, 0);
        chk(psen_n == 1'b1, "R9", psen_n, 1);
        chk(bus_oe == 1'b0, "R9", bus_oe, 0);
        chk(instr_valid == 1'b0, "R9", instr_valid, 0);
        chk(p2_lo == 4'hF, "R9", p2_lo, 4'hF);
        rst_n = 1'b1;
        @(negedge clk); // phase 1 after reset release
        chk(ale == 1'b1, "R1", ale, 1);
        repeat (4) @(negedge clk); // phase 5
        // R1 / R7: idle cycle still strobes, no valid pulse
        do_cycle(1'b0, 12'h123, 1'b1, 2'd0, 1'b0, 4'h0);
        // R4 / R5 / R6: sweep strap, sizes and boundary addresses
        for (int e = 0; e < 2; e++)
            for (int s = 0; s < 4; s++)
                for (int k = 0; k < 10; k++)
                    do_cycle(1'b1, pcs[k], e[0], s[1:0], 1'b0, 4'h0);
        // R8: port write during an external fetch, then during an internal one
        do_cycle(1'b1, 12'hB7E, 1'b1, 2'd3, 1'b1, 4'h6);
        do_cycle(1'b1, 12'h9D2, 1'b0, 2'd1, 1'b0, 4'h0);
        do_cycle(1'b1, 12'h0F0, 1'b0, 2'd3, 1'b1, 4'h9);
        do_cycle(1'b0, 12'h000, 1'b0, 2'd0, 1'b0, 4'h0);
        // R9: reset in mid-cycle
        fetch_req = 1'b1; pc = 12'hE00; ea = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b0; fetch_req = 1'b0;
        @(negedge clk);
        chk(ale == 1'b0 && psen_n == 1'b1 && bus_oe == 1'b0, "R9",
            {ale, psen_n, bus_oe}, 3'b010);
        chk(p2_lo == 4'hF, "R9", p2_lo, 4'hF);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule